// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block keeps a circular queue of in-flight loads in program order and watches for ordering hazards caused by remote cache-line invalidations. The dispatch stage allocates a queue slot per load at the tail and receives the slot index. When the load executes speculatively, the execute stage marks that slot completed and records its address. Retirement frees slots from the head, one per cycle.

A snoop port carries the addresses of invalidated lines. Each snoop is compared in parallel against every live slot, at cache-line granularity. A completed load whose line is invalidated while some older load is still incomplete has observed a value out of order. The block then raises a one-cycle squash request that names the oldest such load. In the same step it moves its own tail back to that slot, so the load and every younger one are discarded and can be dispatched again.

A mode input selects strict load-to-load ordering or relaxed ordering. In relaxed mode only an older incomplete load to the same line makes a hit a violation. Loads that have not completed never cause a squash, because they will read the fresh value when they execute.

Top module: `load_order_guard`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `squash_o`=0 and `alloc_idx_o`=0.
- R2: An allocation is accepted when `alloc_valid_i`=1 and `full_o`=0. `alloc_idx_o` always shows the slot the next allocation gets. Slots are handed out in increasing order modulo DEPTH. With DEPTH loads held, `full_o`=1 and `alloc_valid_i` has no effect.
- R3: `retire_i` frees the oldest slot. When the queue is empty, `retire_i` has no effect.
- R4: A snoop is compared by line address, which is address bits [ADDR_W-1:6] for 64-byte lines. The offset bits [5:0] are ignored, and an address in a different line never hits.
- R5: With `strict_i`=1, a snoop is a violation when its line matches a completed load that has an older incomplete load. In the cycle after the snoop, `squash_o` is high for exactly one cycle and `squash_idx_o` holds that load's slot.
- R6: A snoop hitting only incomplete loads, or completed loads whose older loads are all completed, gives no squash.
- R7: When several loads violate on one snoop, `squash_idx_o` names the oldest of them, meaning the one nearest the head, also when the queue has wrapped.
- R8: On a squash, the tail moves back to the squashed slot. The next allocation gets that slot, and the discarded slots no longer respond to snoops.
- R9: With `strict_i`=0, a hit is a violation only if an older incomplete load has the same line address. That address is taken from `alloc_addr_i` until the load executes, and from `exec_addr_i` afterwards.
- R10: When `retire_i` and a snoop fall in the same cycle, the retiring head load takes no part in the comparison. It neither hits nor counts as an older incomplete load.
- R11: An allocation requested in the same cycle as a snoop that causes a violation is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_i | input | 1 | 1 = strict load ordering, 0 = relaxed (same-line) ordering |
| alloc_valid_i | input | 1 | Allocate a slot for a newly dispatched load |
| alloc_addr_i | input | ADDR_W | Address of the load at dispatch, if known |
| alloc_idx_o | output | log2(DEPTH) | Slot given to the next accepted allocation |
| full_o | output | 1 | No free slot; allocation stalls |
| empty_o | output | 1 | No load in flight |
| exec_valid_i | input | 1 | A load executed; mark its slot completed |
| exec_idx_i | input | log2(DEPTH) | Slot of the executed load |
| exec_addr_i | input | ADDR_W | Address the executed load accessed |
| retire_i | input | 1 | Free the head slot |
| snoop_valid_i | input | 1 | An invalidation is presented |
| snoop_addr_i | input | ADDR_W | Address of the invalidated line |
| squash_o | output | 1 | One-cycle squash request |
| squash_idx_o | output | log2(DEPTH) | Slot of the oldest violating load |

## Verification
The bench builds the block with its defaults: DEPTH=16, ADDR_W=32, LINE_BYTES=64 and the relaxed comparator network present. Sixteen slots let a handful of allocations and retirements fill the queue, push it against the full stall and move the head past the wrap point. This is where the oldest-first choice and the tail rollback must use ages, not raw slot numbers. Keeping the relaxed network in the build lets the bench flip the mode input and compare the same hit pattern under both ordering rules.

// File: rtl/lov_pkg.sv
package lov_pkg;

   typedef enum logic {
      ORD_RELAXED = 1'b0,
      ORD_STRICT  = 1'b1
   } ord_mode_e;

   function automatic bit lov_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lov_ptr_ctrl.sv
module lov_ptr_ctrl #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req_i,
   input  logic             retire_req_i,
   input  logic             roll_req_i,
   input  logic [IDX_W-1:0] roll_age_i,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic [PTR_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o
);

   logic [PTR_W-1:0] head_q, tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + PTR_W'(retire_req_i);
         if (roll_req_i)
            tail_q <= head_q + PTR_W'(roll_age_i);
         else
            tail_q <= tail_q + PTR_W'(alloc_req_i);
      end
   end

   assign head_o  = head_q;
   assign tail_o  = tail_q;
   assign count_o = tail_q - head_q;
   assign full_o  = (count_o == PTR_W'(DEPTH));
   assign empty_o = (count_o == '0);

endmodule

// File: rtl/lov_entry_store.sv
module lov_entry_store #(
   parameter int DEPTH  = 16,
   parameter int LINE_W = 26,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         alloc_we_i,
   input  logic [IDX_W-1:0]             alloc_idx_i,
   input  logic [LINE_W-1:0]            alloc_line_i,
   input  logic                         exec_we_i,
   input  logic [IDX_W-1:0]             exec_idx_i,
   input  logic [LINE_W-1:0]            exec_line_i,
   output logic [DEPTH-1:0]             done_o,
   output logic [DEPTH-1:0][LINE_W-1:0] line_o
);

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic              done_q;
      logic [LINE_W-1:0] line_q;
      logic              hit_alloc, hit_exec;

      assign hit_alloc = alloc_we_i && (alloc_idx_i == IDX_W'(e));
      assign hit_exec  = exec_we_i  && (exec_idx_i  == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            done_q <= 1'b0;
            line_q <= '0;
         end else if (hit_alloc) begin
            done_q <= 1'b0;
            line_q <= alloc_line_i;
         end else if (hit_exec) begin
            done_q <= 1'b1;
            line_q <= exec_line_i;
         end
      end

      assign done_o[e] = done_q;
      assign line_o[e] = line_q;
   end

endmodule

// File: rtl/lov_order_detect.sv
module lov_order_detect
   import lov_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int LINE_W     = 26,
   parameter bit RELAXED_EN = 1'b1,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input  logic [IDX_W-1:0]             head_idx_i,
   input  logic [PTR_W-1:0]             count_i,
   input  logic                         skip_head_i,
   input  logic [DEPTH-1:0]             done_i,
   input  logic [DEPTH-1:0][LINE_W-1:0] line_i,
   input  logic                         snoop_valid_i,
   input  logic [LINE_W-1:0]            snoop_line_i,
   input  logic                         strict_i,
   output logic                         viol_o,
   output logic [IDX_W-1:0]             viol_age_o,
   output logic [IDX_W-1:0]             viol_idx_o
);

   // Everything below is indexed by age: position 0 is the head.
   logic [DEPTH-1:0]             rot_valid, rot_done, pend, hit, older_s, sel, viol_vec;
   logic [DEPTH-1:0][LINE_W-1:0] rot_line;

   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [IDX_W-1:0] phys;
      assign phys         = head_idx_i + IDX_W'(k);
      assign rot_valid[k] = (PTR_W'(k) < count_i) && !(skip_head_i && (k == 0));
      assign rot_done[k]  = done_i[phys];
      assign rot_line[k]  = line_i[phys];
      assign pend[k]      = rot_valid[k] && !rot_done[k];
      assign hit[k]       = rot_valid[k] && rot_done[k] && (rot_line[k] == snoop_line_i);
      if (k == 0) begin : g_first
         assign older_s[k] = 1'b0;
      end else begin : g_chain
         assign older_s[k] = older_s[k-1] | pend[k-1];
      end
   end

   if (RELAXED_EN) begin : g_relaxed
      logic [DEPTH-1:0] older_r;
      for (genvar k = 0; k < DEPTH; k++) begin : g_row
         logic row_hit;
         always_comb begin
            row_hit = 1'b0;
            for (int j = 0; j < k; j++)
               if (pend[j] && (rot_line[j] == rot_line[k]))
                  row_hit = 1'b1;
         end
         assign older_r[k] = row_hit;
      end
      assign sel = (strict_i == ORD_STRICT) ? older_s : older_r;
   end else begin : g_strict_only
      logic unused_mode;
      assign unused_mode = strict_i;
      assign sel = older_s;
   end

   assign viol_vec = {DEPTH{snoop_valid_i}} & hit & sel;
   assign viol_o   = |viol_vec;

   always_comb begin
      viol_age_o = '0;
      for (int k = DEPTH - 1; k >= 0; k--)
         if (viol_vec[k]) viol_age_o = IDX_W'(k);
   end

   assign viol_idx_o = head_idx_i + viol_age_o;

endmodule

// File: rtl/load_order_guard.sv
module load_order_guard
   import lov_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter bit RELAXED_EN = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int PTR_W  = IDX_W + 1,
   localparam int OFFS_W = $clog2(LINE_BYTES),
   localparam int LINE_W = ADDR_W - OFFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strict_i,
   input  logic              alloc_valid_i,
   input  logic [ADDR_W-1:0] alloc_addr_i,
   output logic [IDX_W-1:0]  alloc_idx_o,
   output logic              full_o,
   output logic              empty_o,
   input  logic              exec_valid_i,
   input  logic [IDX_W-1:0]  exec_idx_i,
   input  logic [ADDR_W-1:0] exec_addr_i,
   input  logic              retire_i,
   input  logic              snoop_valid_i,
   input  logic [ADDR_W-1:0] snoop_addr_i,
   output logic              squash_o,
   output logic [IDX_W-1:0]  squash_idx_o
);

   if (!lov_is_pow2(DEPTH) || DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (!lov_is_pow2(LINE_BYTES) || LINE_BYTES < 2) begin : g_chk_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFFS_W) begin : g_chk_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [PTR_W-1:0]             head_ptr, tail_ptr, count;
   logic [IDX_W-1:0]             head_idx, exec_age, viol_age, viol_idx;
   logic                         viol, alloc_req, retire_req, exec_ok;
   logic [DEPTH-1:0]             done;
   logic [DEPTH-1:0][LINE_W-1:0] lines;
   logic                         unused_offs;

   assign head_idx    = head_ptr[IDX_W-1:0];
   assign alloc_idx_o = tail_ptr[IDX_W-1:0];
   assign exec_age    = exec_idx_i - head_idx;
   assign exec_ok     = exec_valid_i && (PTR_W'(exec_age) < count);
   assign alloc_req   = alloc_valid_i && !full_o && !viol;
   assign retire_req  = retire_i && !empty_o;
   assign unused_offs = ^{alloc_addr_i[OFFS_W-1:0], exec_addr_i[OFFS_W-1:0],
                          snoop_addr_i[OFFS_W-1:0]};

   lov_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_req_i  (alloc_req),
      .retire_req_i (retire_req),
      .roll_req_i   (viol),
      .roll_age_i   (viol_age),
      .head_o       (head_ptr),
      .tail_o       (tail_ptr),
      .count_o      (count),
      .full_o       (full_o),
      .empty_o      (empty_o)
   );

   lov_entry_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_we_i   (alloc_req),
      .alloc_idx_i  (alloc_idx_o),
      .alloc_line_i (alloc_addr_i[ADDR_W-1:OFFS_W]),
      .exec_we_i    (exec_ok),
      .exec_idx_i   (exec_idx_i),
      .exec_line_i  (exec_addr_i[ADDR_W-1:OFFS_W]),
      .done_o       (done),
      .line_o       (lines)
   );

   lov_order_detect #(.DEPTH(DEPTH), .LINE_W(LINE_W), .RELAXED_EN(RELAXED_EN)) u_detect (
      .head_idx_i    (head_idx),
      .count_i       (count),
      .skip_head_i   (retire_req),
      .done_i        (done),
      .line_i        (lines),
      .snoop_valid_i (snoop_valid_i),
      .snoop_line_i  (snoop_addr_i[ADDR_W-1:OFFS_W]),
      .strict_i      (strict_i),
      .viol_o        (viol),
      .viol_age_o    (viol_age),
      .viol_idx_o    (viol_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         squash_o     <= 1'b0;
         squash_idx_o <= '0;
      end else begin
         squash_o     <= viol;
         squash_idx_o <= viol ? viol_idx : squash_idx_o;
      end
   end

endmodule

// File: rtl/lov_checker.sv
module lov_checker #(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int PTR_W = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snoop_valid_i,
   input logic             alloc_valid_i,
   input logic             retire_i,
   input logic             squash_o,
   input logic [IDX_W-1:0] squash_idx_o,
   input logic [IDX_W-1:0] head_idx,
   input logic [PTR_W-1:0] tail_ptr,
   input logic [PTR_W-1:0] count,
   input logic             full_o,
   input logic             empty_o
);

   // R5: a squash pulse always answers a snoop of the previous cycle
   p_squash_after_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |-> $past(snoop_valid_i));

   // R6: the head has no older load, so it is never the squashed slot
   p_head_never_squashed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |-> (squash_idx_o != $past(head_idx)));

   // R6: an empty queue cannot produce a violation
   p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |=> !squash_o);

   // R8: the tail sits on the squashed slot right after the squash
   p_tail_rollback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |-> (tail_ptr[IDX_W-1:0] == squash_idx_o));

   // R2: occupancy never exceeds the depth
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PTR_W'(DEPTH));

   // R2: a full queue stays full unless a retirement or a squash frees a slot
   p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !retire_i) |=> (full_o || squash_o));

   // R3: retiring from an empty queue leaves it empty
   p_retire_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && !alloc_valid_i) |=> empty_o);

endmodule

bind load_order_guard lov_checker #(.DEPTH(DEPTH)) u_lov_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .snoop_valid_i (snoop_valid_i),
   .alloc_valid_i (alloc_valid_i),
   .retire_i      (retire_i),
   .squash_o      (squash_o),
   .squash_idx_o  (squash_idx_o),
   .head_idx      (head_idx),
   .tail_ptr      (tail_ptr),
   .count         (count),
   .full_o        (full_o),
   .empty_o       (empty_o)
);

// File: tb/test_load_order_guard.sv
module test_load_order_guard;

   localparam int DEPTH  = 16;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = $clog2(DEPTH);

   localparam logic [3:0] OP_IDLE = 4'd0, OP_ALLOC = 4'd1, OP_EXEC = 4'd2,
                          OP_RETIRE = 4'd3, OP_SNOOP = 4'd4;

   // row: {op[3:0], idx[3:0], addr[31:0], exp_squash, exp_idx[3:0], req[3:0]}
   localparam int NVEC = 18;
   localparam logic [48:0] VEC [NVEC] = '{
      {OP_ALLOC,  4'd0, 32'h0000_1000, 1'b0, 4'd0, 4'd2},
      {OP_ALLOC,  4'd0, 32'h0000_2000, 1'b0, 4'd1, 4'd2},
      {OP_ALLOC,  4'd0, 32'h0000_3000, 1'b0, 4'd2, 4'd2},
      {OP_ALLOC,  4'd0, 32'h0000_4000, 1'b0, 4'd3, 4'd2},
      {OP_EXEC,   4'd2, 32'h0000_3008, 1'b0, 4'd0, 4'd5},
      {OP_EXEC,   4'd3, 32'h0000_4000, 1'b0, 4'd0, 4'd5},
      {OP_SNOOP,  4'd0, 32'h0000_4030, 1'b1, 4'd3, 4'd5},
      {OP_IDLE,   4'd0, 32'h0000_0000, 1'b0, 4'd0, 4'd5},
      {OP_SNOOP,  4'd0, 32'h0000_4000, 1'b0, 4'd0, 4'd8},
      {OP_ALLOC,  4'd0, 32'h0000_5000, 1'b0, 4'd3, 4'd8},
      {OP_EXEC,   4'd0, 32'h0000_1000, 1'b0, 4'd0, 4'd6},
      {OP_EXEC,   4'd1, 32'h0000_2000, 1'b0, 4'd0, 4'd6},
      {OP_SNOOP,  4'd0, 32'h0000_3000, 1'b0, 4'd0, 4'd6},
      {OP_RETIRE, 4'd0, 32'h0000_0000, 1'b0, 4'd0, 4'd3},
      {OP_SNOOP,  4'd0, 32'h0000_1000, 1'b0, 4'd0, 4'd3},
      {OP_SNOOP,  4'd0, 32'h0000_5000, 1'b0, 4'd0, 4'd6},
      {OP_EXEC,   4'd3, 32'h0000_5000, 1'b0, 4'd0, 4'd6},
      {OP_SNOOP,  4'd0, 32'h0000_5020, 1'b0, 4'd0, 4'd6}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              strict_i = 1'b1;
   logic              alloc_valid_i = 1'b0;
   logic [ADDR_W-1:0] alloc_addr_i = '0;
   logic [IDX_W-1:0]  alloc_idx_o;
   logic              full_o, empty_o;
   logic              exec_valid_i = 1'b0;
   logic [IDX_W-1:0]  exec_idx_i = '0;
   logic [ADDR_W-1:0] exec_addr_i = '0;
   logic              retire_i = 1'b0;
   logic              snoop_valid_i = 1'b0;
   logic [ADDR_W-1:0] snoop_addr_i = '0;
   logic              squash_o;
   logic [IDX_W-1:0]  squash_idx_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   load_order_guard i_load_order_guard (
      .clk(clk), .rst_n(rst_n), .strict_i(strict_i),
      .alloc_valid_i(alloc_valid_i), .alloc_addr_i(alloc_addr_i), .alloc_idx_o(alloc_idx_o),
      .full_o(full_o), .empty_o(empty_o),
      .exec_valid_i(exec_valid_i), .exec_idx_i(exec_idx_i), .exec_addr_i(exec_addr_i),
      .retire_i(retire_i), .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
      .squash_o(squash_o), .squash_idx_o(squash_idx_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      alloc_valid_i = 1'b0;
      exec_valid_i  = 1'b0;
      retire_i      = 1'b0;
      snoop_valid_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      strict_i = 1'b1;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic alloc(input logic [ADDR_W-1:0] a, input int exp_idx, input string req);
      alloc_valid_i = 1'b1;
      alloc_addr_i  = a;
      chk(req, int'(alloc_idx_o), exp_idx);
      step();
   endtask

   task automatic exec(input int idx, input logic [ADDR_W-1:0] a);
      exec_valid_i = 1'b1;
      exec_idx_i   = IDX_W'(idx);
      exec_addr_i  = a;
      step();
   endtask

   task automatic snoop(input logic [ADDR_W-1:0] a, input bit exp_sq, input int exp_idx,
                        input string req);
      snoop_valid_i = 1'b1;
      snoop_addr_i  = a;
      step();
      chk(req, int'(squash_o), int'(exp_sq));
      if (exp_sq) chk(req, int'(squash_idx_o), exp_idx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      chk("R1 empty", int'(empty_o), 1);
      chk("R1 full", int'(full_o), 0);
      chk("R1 squash", int'(squash_o), 0);
      chk("R1 alloc_idx", int'(alloc_idx_o), 0);

      // table walk, strict mode
      for (int r = 0; r < NVEC; r++) begin
         logic [3:0]  op, idx, eidx, rq;
         logic [31:0] a;
         logic        sq;
         string       tag;
         {op, idx, a, sq, eidx, rq} = VEC[r];
         tag = $sformatf("R%0d row %0d", rq, r);
         case (op)
            OP_ALLOC: begin
               alloc_valid_i = 1'b1;
               alloc_addr_i  = a;
               chk(tag, int'(alloc_idx_o), int'(eidx));
            end
            OP_EXEC: begin
               exec_valid_i = 1'b1;
               exec_idx_i   = idx;
               exec_addr_i  = a;
            end
            OP_RETIRE: retire_i = 1'b1;
            OP_SNOOP: begin
               snoop_valid_i = 1'b1;
               snoop_addr_i  = a;
            end
            default: ;
         endcase
         step();
         chk(tag, int'(squash_o), int'(sq));
         if (sq) chk(tag, int'(squash_idx_o), int'(eidx));
      end

      // R2/R3: fill, stall on full, wrap
      do_reset();
      for (int i = 0; i < DEPTH; i++) alloc(32'h100 * i, i, "R2 fill");
      chk("R2 full", int'(full_o), 1);
      alloc(32'hF000, 0, "R2 alloc_idx while full");
      chk("R2 full after blocked alloc", int'(full_o), 1);
      retire_i = 1'b1;
      step();
      chk("R3 retire frees slot", int'(full_o), 0);
      alloc(32'hF000, 0, "R2 wrap index");
      chk("R2 full again", int'(full_o), 1);

      // R3: retire on empty has no effect
      do_reset();
      retire_i = 1'b1;
      step();
      chk("R3 empty after retire", int'(empty_o), 1);
      alloc(32'h40, 0, "R3 alloc_idx after empty retire");
      chk("R3 one load held", int'(empty_o), 0);

      // R4/R7: wrapped queue, two violators, oldest wins
      do_reset();
      for (int i = 0; i < 14; i++) alloc(32'h0, i, "R2 pre-fill");
      for (int i = 0; i < 14; i++) begin
         retire_i = 1'b1;
         step();
      end
      chk("R3 drained", int'(empty_o), 1);
      alloc(32'h1000, 14, "R7 alloc 14");
      alloc(32'h2000, 15, "R7 alloc 15");
      alloc(32'h3000, 0, "R7 alloc 0");
      alloc(32'h4000, 1, "R7 alloc 1");
      exec(15, 32'h0000_0040);
      exec(0, 32'h0000_007F);
      snoop(32'h0000_0080, 1'b0, 0, "R4 adjacent line misses");
      snoop(32'h0000_0044, 1'b1, 15, "R7 oldest violator");

      // R9: relaxed ordering
      do_reset();
      strict_i = 1'b0;
      alloc(32'h1000, 0, "R9 alloc 0");
      alloc(32'h2000, 1, "R9 alloc 1");
      exec(1, 32'h2000);
      snoop(32'h2000, 1'b0, 0, "R9 older load on other line");
      alloc(32'h2000, 2, "R9 alloc 2");
      alloc(32'h9000, 3, "R9 alloc 3");
      exec(3, 32'h2010);
      snoop(32'h2020, 1'b1, 3, "R9 older load on same line");
      strict_i = 1'b1;

      // R10: retiring head excluded from comparison
      do_reset();
      alloc(32'h1000, 0, "R10 alloc 0");
      alloc(32'h2000, 1, "R10 alloc 1");
      exec(1, 32'h2000);
      retire_i = 1'b1;
      snoop(32'h2000, 1'b0, 0, "R10 retire with snoop");

      // R11/R8: allocation in a violating cycle is dropped
      do_reset();
      alloc(32'h1000, 0, "R11 alloc 0");
      alloc(32'h2000, 1, "R11 alloc 1");
      alloc(32'h3000, 2, "R11 alloc 2");
      exec(1, 32'h2000);
      alloc_valid_i = 1'b1;
      alloc_addr_i  = 32'h7000;
      snoop(32'h2000, 1'b1, 1, "R11 squash");
      chk("R11 alloc discarded", int'(alloc_idx_o), 1);
      step();
      chk("R5 squash is one pulse", int'(squash_o), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule